// File: doc/BRIEF.md
# SECDED Codec for 64-bit Words with 8 Check Bits

This block protects 64-bit memory words with an 8-bit check byte using an odd-weight-column parity-check matrix. The encoder side turns a write word into its check byte. The decoder side takes a 64-bit read word and its stored 8-bit check byte and recomputes the syndrome. It repairs any single flipped bit, whether in the data or in the check byte, and flags any pattern it cannot repair as uncorrectable.

The decoder reports five things: the repaired data, the raw syndrome, a correctable flag, an uncorrectable flag, and the position of the repaired bit with a valid qualifier. The encoder is always combinational. A parameter selects whether the decoder outputs come straight from logic or pass through one register stage.

Top module: `secded72_codec`

## Requirements
- R1: `wr_check` bit j is the XOR of every `wr_data` bit i whose column has bit j set. The columns, in hex, are, for data bits 0..63 in order: F4 F1 EC EA E9 E6 E5 E3, DC DA D9 D6 D5 D3 CE CB, B5 B0 AD AB A8 A7 A4 A2, 9D 9B 98 97 94 92 8F 8A, 75 70 6D 6B 68 67 64 62, 5E 5B 58 57 54 52 4F 4A, 34 31 2C 2A 29 26 25 23, 1C 1A 19 16 15 13 0E 0B.
- R2: `syndrome` equals `rd_check` XOR the check byte that R1 would compute from `rd_data`.
- R3: A zero syndrome gives `fix_data` equal to `rd_data`, both flags low, `flip_vld` low and `flip_idx` zero.
- R4: A syndrome equal to the column of data bit i gives `fix_data` equal to `rd_data` with bit i inverted, `err_ce` high, `flip_vld` high and `flip_idx` equal to i.
- R5: A syndrome with only bit j set (a flipped check bit j) leaves `fix_data` equal to `rd_data` and gives `err_ce` high, `flip_vld` high and `flip_idx` equal to 64+j.
- R6: Any other nonzero syndrome gives `err_ue` high, `err_ce` low, `fix_data` equal to the uncorrected `rd_data`, `flip_vld` low and `flip_idx` zero. This covers every even-weight syndrome (such as 0x03 from two flipped check bits) and every odd-weight syndrome that matches no column.
- R7: `err_ce` and `err_ue` are never high together.
- R8: With `PIPE`=1 the decoder outputs appear on the clock edge after the read inputs, and while `rst_n` is low they are all zero. With `PIPE`=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 64 | Word to encode |
| wr_check | output | 8 | Check byte for `wr_data` |
| rd_data | input | 64 | Data part of the read word |
| rd_check | input | 8 | Stored check byte of the read word |
| fix_data | output | 64 | Corrected data |
| syndrome | output | 8 | Computed syndrome |
| err_ce | output | 1 | Single-bit error repaired |
| err_ue | output | 1 | Uncorrectable error |
| flip_idx | output | 7 | Repaired bit position: 0..63 data, 64..71 check |
| flip_vld | output | 1 | `flip_idx` is meaningful |

## Verification
The bench builds the block with `PIPE`=1, so the reset behaviour and the one-cycle latency can be observed. Because the codec itself is small, every one of the 72 single-bit flips can be swept on several words, which exercises every table column and every check-bit position. Random double flips, the two-check-bit syndrome 0x03, and random corrupt check bytes reach the uncorrectable path. A walking-one sweep over the data checks the encoder against the column table bit by bit.

// File: rtl/secded72_codec.sv
module secded72_codec #(
  parameter int PIPE = 1,
  localparam int DW = 64,
  localparam int CW = 8,
  localparam int NB = DW + CW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] wr_check,
  input  logic [DW-1:0] rd_data,
  input  logic [CW-1:0] rd_check,
  output logic [DW-1:0] fix_data,
  output logic [CW-1:0] syndrome,
  output logic          err_ce,
  output logic          err_ue,
  output logic [IW-1:0] flip_idx,
  output logic          flip_vld
);

  function automatic logic [CW-1:0] col(input int i);
    case (i)
      0: col = 8'hF4;  1: col = 8'hF1;  2: col = 8'hEC;  3: col = 8'hEA;
      4: col = 8'hE9;  5: col = 8'hE6;  6: col = 8'hE5;  7: col = 8'hE3;
      8: col = 8'hDC;  9: col = 8'hDA; 10: col = 8'hD9; 11: col = 8'hD6;
     12: col = 8'hD5; 13: col = 8'hD3; 14: col = 8'hCE; 15: col = 8'hCB;
     16: col = 8'hB5; 17: col = 8'hB0; 18: col = 8'hAD; 19: col = 8'hAB;
     20: col = 8'hA8; 21: col = 8'hA7; 22: col = 8'hA4; 23: col = 8'hA2;
     24: col = 8'h9D; 25: col = 8'h9B; 26: col = 8'h98; 27: col = 8'h97;
     28: col = 8'h94; 29: col = 8'h92; 30: col = 8'h8F; 31: col = 8'h8A;
     32: col = 8'h75; 33: col = 8'h70; 34: col = 8'h6D; 35: col = 8'h6B;
     36: col = 8'h68; 37: col = 8'h67; 38: col = 8'h64; 39: col = 8'h62;
     40: col = 8'h5E; 41: col = 8'h5B; 42: col = 8'h58; 43: col = 8'h57;
     44: col = 8'h54; 45: col = 8'h52; 46: col = 8'h4F; 47: col = 8'h4A;
     48: col = 8'h34; 49: col = 8'h31; 50: col = 8'h2C; 51: col = 8'h2A;
     52: col = 8'h29; 53: col = 8'h26; 54: col = 8'h25; 55: col = 8'h23;
     56: col = 8'h1C; 57: col = 8'h1A; 58: col = 8'h19; 59: col = 8'h16;
     60: col = 8'h15; 61: col = 8'h13; 62: col = 8'h0E; 63: col = 8'h0B;
      default: col = '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++) c = c ^ (d[i] ? col(i) : '0);
    return c;
  endfunction

  logic [CW-1:0] syn_c;
  logic [DW-1:0] hit;
  logic          chk_hit, ce_c, ue_c;
  logic [IW-1:0] idx_c;
  logic [DW-1:0] fix_c;

  assign wr_check = enc(wr_data);
  assign syn_c    = rd_check ^ enc(rd_data);

  always_comb begin
    hit     = '0;
    chk_hit = 1'b0;
    idx_c   = '0;
    for (int i = 0; i < DW; i++) begin
      hit[i] = (syn_c == col(i));
      if (hit[i]) idx_c = IW'(i);
    end
    for (int j = 0; j < CW; j++) begin
      if (syn_c == (CW'(1) << j)) begin
        chk_hit = 1'b1;
        idx_c   = IW'(DW + j);
      end
    end
  end

  assign ce_c  = (|hit) | chk_hit;
  assign ue_c  = (syn_c != '0) && !ce_c;
  assign fix_c = rd_data ^ hit;

  generate
    if (PIPE != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          fix_data <= '0;
          syndrome <= '0;
          err_ce   <= 1'b0;
          err_ue   <= 1'b0;
          flip_idx <= '0;
          flip_vld <= 1'b0;
        end else begin
          fix_data <= fix_c;
          syndrome <= syn_c;
          err_ce   <= ce_c;
          err_ue   <= ue_c;
          flip_idx <= idx_c;
          flip_vld <= ce_c;
        end
      end
    end else begin : g_comb
      assign fix_data = fix_c;
      assign syndrome = syn_c;
      assign err_ce   = ce_c;
      assign err_ue   = ue_c;
      assign flip_idx = idx_c;
      assign flip_vld = ce_c;
    end
  endgenerate

  // R3
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_c == '0) |-> (fix_c == rd_data && !ce_c && !ue_c));

  // R4
  single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_c |-> ($countones(fix_c ^ rd_data) <= 1 && $countones(syn_c) % 2 == 1));

  // R6
  ue_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_c |-> (fix_c == rd_data));

  // R6
  even_syn_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_c != '0 && $countones(syn_c) % 2 == 0) |-> ue_c);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_ce && err_ue));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_vld |-> (flip_idx < IW'(NB)));

endmodule

// File: tb/secded72_codec_bench.sv
module secded72_codec_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0, rd_data = '0, fix_data;
  logic [7:0]  rd_check = '0, wr_check, syndrome;
  logic        err_ce, err_ue, flip_vld;
  logic [6:0]  flip_idx;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  secded72_codec #(.PIPE(1)) u_secded72_codec (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_data(rd_data), .rd_check(rd_check), .fix_data(fix_data),
    .syndrome(syndrome), .err_ce(err_ce), .err_ue(err_ue),
    .flip_idx(flip_idx), .flip_vld(flip_vld));

  logic [7:0] tbl [64];
  initial begin
    tbl = '{8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
            8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
            8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
            8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
            8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
            8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
            8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
            8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};
  end

  function automatic logic [7:0] benc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 64; i++)
        if (tbl[i][j]) c[j] = c[j] ^ d[i];
    return c;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic drive(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    rd_data = d; rd_check = c; wr_data = d;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] ed, input logic [7:0] es,
                     input logic ece, input logic eue, input logic ev, input logic [6:0] ei);
    n_chk++;
    if (fix_data !== ed || syndrome !== es || err_ce !== ece || err_ue !== eue ||
        flip_vld !== ev || flip_idx !== ei) begin
      n_fail++;
      $display("FAIL %s: got data=%h syn=%h ce=%b ue=%b vld=%b idx=%0d exp data=%h syn=%h ce=%b ue=%b vld=%b idx=%0d",
               tag, fix_data, syndrome, err_ce, err_ue, flip_vld, flip_idx,
               ed, es, ece, eue, ev, ei);
    end
  endtask

  task automatic chk_enc(input string tag, input logic [63:0] d);
    n_chk++;
    if (wr_check !== benc(d)) begin
      n_fail++;
      $display("FAIL %s: check byte got=%h exp=%h", tag, wr_check, benc(d));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d, e;
    logic [7:0]  s, c;
    int a, b, hit_i;
    rd_data = 64'hFFFF_FFFF_FFFF_FFFF; rd_check = 8'h03;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset", '0, '0, 0, 0, 0, '0);
    rst_n = 1'b1;

    // R1: walking ones, corner patterns and random words
    for (int i = 0; i < 64; i++) begin
      drive(64'd1 << i, '0);
      chk_enc("R1 walk", 64'd1 << i);
    end
    drive('0, '0);                       chk_enc("R1 zero", '0);
    drive({64{1'b1}}, '0);               chk_enc("R1 ones", {64{1'b1}});
    for (int k = 0; k < 16; k++) begin d = rnd64(); drive(d, '0); chk_enc("R1 rand", d); end

    // R3/R2: clean words
    for (int k = 0; k < 8; k++) begin
      d = (k == 0) ? '0 : (k == 1) ? {64{1'b1}} : rnd64();
      drive(d, benc(d));
      chk("R3 clean", d, 8'h00, 0, 0, 0, '0);
    end

    // R4/R5: all 72 single flips on several words
    for (int w = 0; w < 3; w++) begin
      d = (w == 0) ? 64'h0123_4567_89AB_CDEF : rnd64();
      c = benc(d);
      for (int i = 0; i < 64; i++) begin
        drive(d ^ (64'd1 << i), c);
        chk("R4 data flip", d, tbl[i], 1, 0, 1, 7'(i));
      end
      for (int j = 0; j < 8; j++) begin
        drive(d, c ^ (8'd1 << j));
        chk("R5 check flip", d, 8'd1 << j, 1, 0, 1, 7'(64 + j));
      end
    end

    // R6: two flipped check bits -> syndrome 0x03
    d = rnd64();
    drive(d, benc(d) ^ 8'h03);
    chk("R6 syn03", d, 8'h03, 0, 1, 0, '0);

    // R6/R7: random double flips anywhere among the 72 bits
    for (int k = 0; k < 300; k++) begin
      d = rnd64(); c = benc(d);
      a = int'($urandom_range(71)); b = int'($urandom_range(70));
      if (b >= a) b++;
      e = d;
      if (a < 64) e[a] = ~e[a]; else c[a-64] = ~c[a-64];
      if (b < 64) e[b] = ~e[b]; else c[b-64] = ~c[b-64];
      s = c ^ benc(e);
      drive(e, c);
      chk("R6 double", e, s, 0, 1, 0, '0);
    end

    // R2/R6/R7: arbitrary check bytes, expectation from the column rules
    for (int k = 0; k < 200; k++) begin
      d = rnd64(); c = 8'($urandom());
      s = c ^ benc(d);
      hit_i = -1;
      for (int i = 0; i < 64; i++) if (tbl[i] == s) hit_i = i;
      drive(d, c);
      if (s == 0) chk("R2 arb clean", d, s, 0, 0, 0, '0);
      else if (hit_i >= 0) chk("R4 arb", d ^ (64'd1 << hit_i), s, 1, 0, 1, 7'(hit_i));
      else if ($countones(s) == 1) begin
        for (int j = 0; j < 8; j++) if (s == (8'd1 << j)) hit_i = 64 + j;
        chk("R5 arb", d, s, 1, 0, 1, 7'(hit_i));
      end else chk("R6 arb", d, s, 0, 1, 0, '0);
    end

    // R8: reset clears outputs after an error was showing
    d = rnd64();
    drive(d, benc(d) ^ 8'h03);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset again", '0, '0, 0, 0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule